// File: doc/BRIEF.md
# Load/Store Address Generator

This block turns the operands of a load or store instruction into the byte address sent to memory, the value to be written back into the base register, and a strobe that says whether that writeback happens. The offset is either a 12-bit unsigned immediate or an index register shifted left by a programmable amount. The offset is added to or subtracted from the base. Four addressing modes decide which sum becomes the address and whether the base register is updated.

The same address also drives a set of byte-lane enables for the data bus. These enables cover byte, halfword and word transfers in either byte order. The byte order is captured from a configuration pin while reset is held, and stays fixed until the next reset.

The datapath is combinational from operands to outputs. The only state is the captured byte-order bit. The register file, the memory port and alignment faults belong to the surrounding pipeline.

Top module: `lsu_addr_gen`

## Requirements
- R1: Mode code 2'b11 (indirect) forces the offset to zero: `ea` equals `base`, `wb_data` equals `base`, and `wb_en` is 0.
- R2: Mode code 2'b00 (offset) gives `ea` = base ± offset and leaves `wb_en` at 0.
- R3: Mode code 2'b01 (pre-index with update) gives `ea` = base ± offset, puts the same value on `wb_data`, and asserts `wb_en`.
- R4: Mode code 2'b10 (post-index) gives `ea` = `base` unchanged, puts base ± offset on `wb_data`, and asserts `wb_en`.
- R5: With `sub_off` = 1 the offset is subtracted from the base, otherwise it is added. Either result wraps modulo 2^32.
- R6: With `use_idx` = 1 the offset is `idx` shifted left by `shamt` (0 to 31), and bits shifted out are lost. With `use_idx` = 0 the offset is `imm` zero-extended, and `shamt` and `idx` have no effect.
- R7: Size code 2'b10 (word) enables all four lanes (`lane_en` = 4'b1111) whatever the low address bits.
- R8: Size code 2'b01 (halfword) enables two lanes chosen by `ea[1]`. In little-endian order, `ea[1]`=0 gives 4'b0011 and `ea[1]`=1 gives 4'b1100. In big-endian order these two patterns swap.
- R9: Size code 2'b00 (byte) enables one lane. In little-endian order the lane is `ea[1:0]`; in big-endian order it is 3 − `ea[1:0]`. Lane n covers data bits 8n+7..8n.
- R10: Size code 2'b11 enables no lane (`lane_en` = 4'b0000).
- R11: Byte order is taken from `cfg_big_end` (1 = big-endian) on every rising clock edge while `rst_n` is low. Changes on `cfg_big_end` while `rst_n` is high have no effect on `lane_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the byte-order capture |
| rst_n | input | 1 | Active-low synchronous reset; byte order is sampled while low |
| cfg_big_end | input | 1 | Byte-order select, 1 = big-endian |
| base | input | 32 | Base register value |
| idx | input | 32 | Index register value |
| imm | input | 12 | Unsigned immediate offset |
| shamt | input | 5 | Left-shift amount applied to the index |
| use_idx | input | 1 | 1 = index register offset, 0 = immediate |
| sub_off | input | 1 | 1 = subtract the offset from the base |
| mode | input | 2 | Addressing mode: 00 offset, 01 pre-update, 10 post-index, 11 indirect |
| size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 none |
| ea | output | 32 | Effective byte address |
| wb_data | output | 32 | Value for the base register |
| wb_en | output | 1 | Base register writeback strobe |
| lane_en | output | 4 | Byte-lane enables, bit n = data byte n |

## Verification
In the same cycle, the block updates the base register and picks byte lanes from an address that may not be the updated one. In post-index mode the lanes must follow the old base, while `wb_data` carries a sum whose low two bits differ from it. The bench provokes this with offsets that are not multiples of four, in both byte orders and with subtraction. A lane pattern taken from `wb_data` instead of `ea` shows up as a mismatch against the expected enables.

// File: rtl/lsu_ag_pkg.sv
package lsu_ag_pkg;

   typedef enum logic [1:0] {
      AM_OFFSET   = 2'b00,
      AM_PRE_WB   = 2'b01,
      AM_POST     = 2'b10,
      AM_INDIRECT = 2'b11
   } amode_e;

   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
   localparam logic [1:0] SZ_WORD = 2'b10;
   localparam logic [1:0] SZ_NONE = 2'b11;

   typedef struct packed {
      logic use_idx;
      logic sub_off;
      amode_e mode;
   } agen_ctl_t;

endpackage

// File: rtl/lsu_ag_offset.sv
module lsu_ag_offset #(
   parameter int AW       = 32,
   parameter int IMM_W    = 12,
   parameter int SH_W     = 5,
   parameter bit SCALE_EN = 1'b1
) (
   input  logic [AW-1:0]    idx,
   input  logic [IMM_W-1:0] imm,
   input  logic [SH_W-1:0]  shamt,
   input  logic             use_idx,
   input  logic             force_zero,
   output logic [AW-1:0]    offset
);
   localparam int PAD_W = AW - IMM_W;

   logic [AW-1:0] imm_ext;
   logic [AW-1:0] idx_term;

   assign imm_ext = {{PAD_W{1'b0}}, imm};

   generate
      if (SCALE_EN) begin : g_scaled
         assign idx_term = idx << shamt;
      end else begin : g_plain
         logic unused_sh;
         assign unused_sh = ^shamt;
         assign idx_term  = idx;
      end
   endgenerate

   always_comb begin
      if (force_zero)   offset = '0;
      else if (use_idx) offset = idx_term;
      else              offset = imm_ext;
   end
endmodule

// File: rtl/lsu_ag_sum.sv
module lsu_ag_sum
   import lsu_ag_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] offset,
   input  logic          sub_off,
   input  amode_e        mode,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] wb_data,
   output logic          wb_en
);
   logic [AW-1:0] moved;

   always_comb begin
      if (sub_off) moved = base - offset;
      else         moved = base + offset;
   end

   always_comb begin
      unique case (mode)
         AM_OFFSET:   begin ea = moved; wb_en = 1'b0; end
         AM_PRE_WB:   begin ea = moved; wb_en = 1'b1; end
         AM_POST:     begin ea = base;  wb_en = 1'b1; end
         default:     begin ea = base;  wb_en = 1'b0; end
      endcase
   end

   assign wb_data = moved;
endmodule

// File: rtl/lsu_ag_lanes.sv
module lsu_ag_lanes #(
   parameter int LANES = 4,
   parameter int LG    = $clog2(LANES)
) (
   input  logic [LG-1:0]    addr_lo,
   input  logic [1:0]       size,
   input  logic             big_end,
   output logic [LANES-1:0] lane_en
);
   localparam logic [1:0] MAX_SZ = 2'(LG);

   logic size_ok;
   logic [LG-1:0] grp;

   assign size_ok = (size <= MAX_SZ);
   assign grp     = addr_lo >> size;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         localparam logic [LG-1:0] POS_LE = LG'(i);
         localparam logic [LG-1:0] POS_BE = LG'(LANES - 1 - i);
         logic [LG-1:0] pos;
         assign pos        = big_end ? POS_BE : POS_LE;
         assign lane_en[i] = size_ok && ((pos >> size) == grp);
      end
   endgenerate
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
   import lsu_ag_pkg::*;
#(
   parameter int AW       = 32,
   parameter int IMM_W    = 12,
   parameter int SH_W     = 5,
   parameter int LANES    = 4,
   parameter bit SCALE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_big_end,
   input  logic [AW-1:0]    base,
   input  logic [AW-1:0]    idx,
   input  logic [IMM_W-1:0] imm,
   input  logic [SH_W-1:0]  shamt,
   input  logic             use_idx,
   input  logic             sub_off,
   input  logic [1:0]       mode,
   input  logic [1:0]       size,
   output logic [AW-1:0]    ea,
   output logic [AW-1:0]    wb_data,
   output logic             wb_en,
   output logic [LANES-1:0] lane_en
);
   localparam int LG = $clog2(LANES);

   generate
      if (IMM_W >= AW) begin : g_bad_imm
         $error("lsu_addr_gen: IMM_W must be narrower than AW");
      end
      if ((LANES < 2) || (LANES > 8) || ((1 << LG) != LANES)) begin : g_bad_lanes
         $error("lsu_addr_gen: LANES must be 2, 4 or 8");
      end
      if ((1 << SH_W) > AW) begin : g_bad_sh
         $error("lsu_addr_gen: SH_W too wide for AW");
      end
   endgenerate

   agen_ctl_t     ctl;
   logic [AW-1:0] offset;
   logic          be_q;

   assign ctl.use_idx = use_idx;
   assign ctl.sub_off = sub_off;
   assign ctl.mode    = amode_e'(mode);

   always_ff @(posedge clk) begin
      if (!rst_n) be_q <= cfg_big_end;
   end

   lsu_ag_offset #(
      .AW(AW), .IMM_W(IMM_W), .SH_W(SH_W), .SCALE_EN(SCALE_EN)
   ) u_off (
      .idx       (idx),
      .imm       (imm),
      .shamt     (shamt),
      .use_idx   (ctl.use_idx),
      .force_zero(ctl.mode == AM_INDIRECT),
      .offset    (offset)
   );

   lsu_ag_sum #(.AW(AW)) u_sum (
      .base   (base),
      .offset (offset),
      .sub_off(ctl.sub_off),
      .mode   (ctl.mode),
      .ea     (ea),
      .wb_data(wb_data),
      .wb_en  (wb_en)
   );

   lsu_ag_lanes #(.LANES(LANES), .LG(LG)) u_lanes (
      .addr_lo(ea[LG-1:0]),
      .size   (size),
      .big_end(be_q),
      .lane_en(lane_en)
   );
endmodule

// File: rtl/lsu_ag_chk.sv
module lsu_ag_chk #(
   parameter int AW    = 32,
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AW-1:0]    base,
   input logic [1:0]       mode,
   input logic [1:0]       size,
   input logic [AW-1:0]    ea,
   input logic [AW-1:0]    wb_data,
   input logic             wb_en,
   input logic [LANES-1:0] lane_en,
   input logic             be_q
);
   localparam logic [1:0] MAX_SZ = 2'($clog2(LANES));

   AST_INDIRECT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |-> (ea == base && wb_data == base && !wb_en)); // R1
   AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> !wb_en); // R2
   AST_PRE_WB_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |-> (wb_en && ea == wb_data)); // R3
   AST_POST_OLD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |-> (wb_en && ea == base)); // R4
   AST_WB_ONLY_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (mode == 2'b01 || mode == 2'b10)); // R3
   AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (size <= MAX_SZ) |-> ($countones(lane_en) == (32'd1 << size))); // R7
   AST_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (size > MAX_SZ) |-> (lane_en == '0)); // R10
   AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(be_q)); // R11
endmodule

bind lsu_addr_gen lsu_ag_chk #(.AW(AW), .LANES(LANES)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .base   (base),
   .mode   (mode),
   .size   (size),
   .ea     (ea),
   .wb_data(wb_data),
   .wb_en  (wb_en),
   .lane_en(lane_en),
   .be_q   (be_q)
);

// File: tb/lsu_addr_gen_tb.sv
module lsu_addr_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_big_end = 1'b0;
   logic [31:0] base = '0;
   logic [31:0] idx = '0;
   logic [11:0] imm = '0;
   logic [4:0]  shamt = '0;
   logic        use_idx = 1'b0;
   logic        sub_off = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [1:0]  size = 2'b10;
   logic [31:0] ea;
   logic [31:0] wb_data;
   logic        wb_en;
   logic [3:0]  lane_en;

   int total = 0;
   int bad = 0;
   bit tb_big = 1'b0;

   always #2 clk = ~clk;

   lsu_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_big_end(cfg_big_end),
      .base(base), .idx(idx), .imm(imm), .shamt(shamt),
      .use_idx(use_idx), .sub_off(sub_off), .mode(mode), .size(size),
      .ea(ea), .wb_data(wb_data), .wb_en(wb_en), .lane_en(lane_en)
   );

   function automatic logic [31:0] f_off(logic ui, logic [11:0] im, logic [31:0] ix,
                                         logic [4:0] sh, logic [1:0] md);
      if (md == 2'b11) return 32'd0;
      if (ui) return ix << sh;
      return {20'd0, im};
   endfunction

   function automatic logic [3:0] f_lanes(logic [1:0] a, logic [1:0] sz, logic be);
      case (sz)
         2'b00: return be ? (4'b1000 >> a) : (4'b0001 << a);
         2'b01: return (a[1] ^ be) ? 4'b1100 : 4'b0011;
         2'b10: return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h (mode=%b size=%b base=%h)", tag, got, exp, mode, size, base);
      end
   endtask

   task automatic apply_check(logic [31:0] b, logic [31:0] ix, logic [11:0] im,
                              logic [4:0] sh, logic ui, logic sb, logic [1:0] md,
                              logic [1:0] sz);
      logic [31:0] off, mv, e_ea;
      @(negedge clk);
      base = b; idx = ix; imm = im; shamt = sh; use_idx = ui;
      sub_off = sb; mode = md; size = sz;
      #1;
      off  = f_off(ui, im, ix, sh, md);
      mv   = sb ? b - off : b + off;
      e_ea = (md == 2'b10 || md == 2'b11) ? b : mv;
      case (md)
         2'b00: check("R2 ea", ea, e_ea);
         2'b01: check("R3 ea", ea, e_ea);
         2'b10: check("R4 ea", ea, e_ea);
         default: check("R1 ea", ea, e_ea);
      endcase
      check(md == 2'b11 ? "R1 wb_data" : "R5 wb_data", wb_data, mv);
      check("R3 R4 wb_en", {31'd0, wb_en}, {31'd0, (md == 2'b01 || md == 2'b10)});
      check("R9 lane_en", {28'd0, lane_en}, {28'd0, f_lanes(e_ea[1:0], sz, tb_big)});
   endtask

   task automatic do_reset(logic be);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_big_end = be;
      tb_big = be;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic random_run(int n);
      for (int k = 0; k < n; k++) begin
         apply_check($urandom, $urandom, 12'($urandom), 5'($urandom), 1'($urandom),
                     1'($urandom), 2'($urandom), 2'($urandom));
      end
   endtask

   initial begin
      #(4 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      do_reset(1'b0);
      // reset state: little-endian byte lanes after reset
      apply_check(32'h0000_1001, 0, 0, 0, 0, 0, 2'b11, 2'b00);
      check("R11 reset le", {28'd0, lane_en}, 32'h2);
      // R1 indirect ignores offset
      apply_check(32'h1000_0000, 32'hFFFF, 12'hFFF, 5'd4, 1, 0, 2'b11, 2'b10);
      // R5 wrap on subtract / add
      apply_check(32'h0, 0, 12'd4, 0, 0, 1, 2'b00, 2'b10);
      check("R5 wrap sub", ea, 32'hFFFF_FFFC);
      apply_check(32'hFFFF_FFFF, 0, 12'd1, 0, 0, 0, 2'b01, 2'b10);
      check("R5 wrap add", ea, 32'h0);
      // R6 scaled index, bits shifted out
      apply_check(32'h0, 32'h3, 0, 5'd31, 1, 0, 2'b00, 2'b10);
      check("R6 shift31", ea, 32'h8000_0000);
      apply_check(32'h100, 32'h5, 0, 5'd2, 1, 1, 2'b01, 2'b10);
      check("R6 word index", wb_data, 32'hEC);
      // R6 shamt and idx ignored for immediate
      apply_check(32'h100, 32'hDEAD, 12'h10, 5'd7, 0, 0, 2'b00, 2'b10);
      check("R6 imm only", ea, 32'h110);
      // R4 post-index, lanes follow old base (R8/R9)
      apply_check(32'h2000, 0, 12'd3, 0, 0, 0, 2'b10, 2'b00);
      check("R9 post byte lane", {28'd0, lane_en}, 32'h1);
      apply_check(32'h2002, 0, 12'd2, 0, 0, 1, 2'b10, 2'b01);
      check("R8 post half", {28'd0, lane_en}, 32'hC);
      // R7 word ignores low bits, R10 none
      apply_check(32'h3, 0, 0, 0, 0, 0, 2'b11, 2'b10);
      check("R7 word", {28'd0, lane_en}, 32'hF);
      apply_check(32'h3, 0, 0, 0, 0, 0, 2'b11, 2'b11);
      check("R10 none", {28'd0, lane_en}, 32'h0);
      random_run(400);

      do_reset(1'b1);
      apply_check(32'h0, 0, 0, 0, 0, 0, 2'b11, 2'b00);
      check("R9 be byte0", {28'd0, lane_en}, 32'h8);
      apply_check(32'h2, 0, 0, 0, 0, 0, 2'b11, 2'b01);
      check("R8 be half", {28'd0, lane_en}, 32'h3);
      // R11 pin change after reset has no effect
      @(negedge clk);
      cfg_big_end = 1'b0;
      repeat (3) @(negedge clk);
      apply_check(32'h1, 0, 0, 0, 0, 0, 2'b11, 2'b00);
      check("R11 order held", {28'd0, lane_en}, 32'h4);
      apply_check(32'h4000, 0, 12'd1, 0, 0, 0, 2'b10, 2'b00);
      check("R9 be post", {28'd0, lane_en}, 32'h8);
      random_run(400);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule